// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a write-back, direct-mapped data cache that keeps a small, fully associative victim buffer beside its main array. A processor issues single-word reads and writes. The processor holds the request until the cache answers with a ready pulse. On the far side, a block-wide port moves whole lines to and from lower memory through a request/acknowledge handshake, one transaction at a time.

A line pushed out of the main array is never dropped. It is parked in the victim buffer, which is indexed by a rotating pointer. When the main array misses, the victim buffer is searched by full block address before memory is involved. A victim hit exchanges the two lines in one step. Only a miss in both structures reaches memory. If the slot about to be reused holds a modified line, that line is written to memory before the new block is fetched. Dirty state moves with each line wherever it goes.

CPU addresses are word addresses. Bits [1:0] select the word within a four-word line, bits [9:2] select one of 256 lines (4 KB by default), and bits [15:10] form the tag. The memory port carries block addresses, which are the CPU address without its two word-select bits.

Top module: `victim_dm_cache`

## Requirements
- R1: After reset, every line in the main array and in the victim buffer is invalid. The first access to any address fetches its block from memory. `cpu_ready` and `mem_req` stay low while no request is present.
- R2: A request that hits the main array asserts `cpu_ready` in its first cycle and makes no memory request. A write hit replaces only the addressed word (bits [1:0] of `cpu_addr`) and marks the line modified.
- R3: On a main-array miss, the victim buffer is searched before memory. A victim hit asserts `cpu_ready` in the second cycle of the request and issues no memory request.
- R4: On a victim hit, the requested line moves into the main array and the displaced main-array line takes the same victim slot. A write on a victim hit is merged into the moved line. A block is never present in both structures.
- R5: A miss in both structures fetches the block from memory. A valid displaced main-array line is stored in the victim slot at the rotating pointer, and the pointer then advances. A write miss allocates the line and merges the written word.
- R6: When the slot at the pointer holds a valid modified line and a new victim must go there, that line is written to memory at its own block address before the read of the new block. A clean line there is overwritten without any memory write.
- R7: The modified state of a line is kept through moves between main array and victim buffer. A line written once and then swapped back and forth still reaches memory with its written data when finally pushed out.
- R8: Once `mem_req` is raised, it stays high, with `mem_we`, `mem_addr` and `mem_wdata` unchanged, until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_valid | input | 1 | Request present, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address: tag, line index, word select |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 14 | Block address |
| mem_wdata | output | 128 | Block being written |
| mem_rdata | input | 128 | Block returned, valid with `mem_ack` |
| mem_ack | input | 1 | Transaction done, one-cycle pulse |

## Verification
The hardest case to reach from the ports is a write-back of a modified line out of the victim buffer. This needs a line that was written, pushed into the buffer, swapped back and forth, and then aged past every other slot. The stimulus builds this at one line index. It writes a line, forces a conflict miss, swaps the two lines twice, and then streams three more conflicting tags so the rotating pointer wraps to the modified slot. A fifth conflict then triggers the write-back. The bench checks the written block address and data, and that the write precedes the read. A final re-read of the evicted address confirms no data was lost.

// File: rtl/vcache_pkg.sv
// Shared definitions for the victim-buffered cache.
package vcache_pkg;
    // Controller phases: idle/lookup, victim swap, write-back, block fill.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWAP  = 2'd1,
        ST_WBACK = 2'd2,
        ST_FILL  = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/vc_main_array.sv
// Direct-mapped line storage: tag, data, valid and dirty per line.
// Assumes one read index and one write index per cycle; reads are
// combinational, writes land at the clock edge. Only valid/dirty reset.
module vc_main_array #(
    parameter int LINES  = 256,
    parameter int TAG_W  = 6,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    output logic              rd_valid,
    output logic              rd_dirty,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_dirty
);
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] line_q [LINES];
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;

    // Combinational read of the addressed line.
    always_comb begin
        rd_tag   = tag_q[idx];
        rd_line  = line_q[idx];
        rd_valid = valid_q[idx];
        rd_dirty = dirty_q[idx];
    end

    // Status bits: cleared by reset, set on every line install/update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= wr_dirty;
        end
    end

    // Tag and data storage, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= wr_tag;
            line_q[idx] <= wr_line;
        end
    end
endmodule

// File: rtl/vc_victim_buf.sv
// Fully associative victim store, matched on full block address.
// Slots are reused in rotating order; the pointer names the oldest
// insertion position. Assumes ENTRIES >= 2.
module vc_victim_buf #(
    parameter int ENTRIES = 4,
    parameter int BLK_W   = 14,
    parameter int LINE_W  = 128,
    localparam int SLOT_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  look_blk,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [LINE_W-1:0] hit_line,
    output logic              hit_dirty,
    output logic [SLOT_W-1:0] head_slot,
    output logic              head_valid,
    output logic              head_dirty,
    output logic [BLK_W-1:0]  head_blk,
    output logic [LINE_W-1:0] head_line,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_dirty,
    input  logic              advance
);
    logic [BLK_W-1:0]   blk_q   [ENTRIES];
    logic [LINE_W-1:0]  line_q  [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [ENTRIES-1:0] match;
    logic [SLOT_W-1:0]  ptr_q;

    // One comparator per slot.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = valid_q[e] && (blk_q[e] == look_blk);
    end

    // Encode the matching slot and present its contents.
    always_comb begin
        hit_slot = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) hit_slot = SLOT_W'(e);
        end
        hit       = |match;
        hit_line  = line_q[hit_slot];
        hit_dirty = dirty_q[hit_slot];
    end

    // Oldest slot, the next one to be reused.
    always_comb begin
        head_slot  = ptr_q;
        head_valid = valid_q[ptr_q];
        head_dirty = dirty_q[ptr_q];
        head_blk   = blk_q[ptr_q];
        head_line  = line_q[ptr_q];
    end

    // Slot status and the rotating pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (wr_en) begin
                valid_q[wr_slot] <= wr_valid;
                dirty_q[wr_slot] <= wr_valid && wr_dirty;
            end
            if (advance) begin
                ptr_q <= (ptr_q == SLOT_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // Slot payload.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            blk_q[wr_slot]  <= wr_blk;
            line_q[wr_slot] <= wr_line;
        end
    end

    // A block may sit in at most one slot.
    p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/victim_dm_cache.sv
// Write-back direct-mapped cache with a victim buffer.
// Lookup order: main array, then victim buffer, then memory.
// Assumes the CPU holds its request stable until cpu_ready, and memory
// answers each request with a single-cycle mem_ack.
module victim_dm_cache
    import vcache_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int CACHE_BYTES = 4096,
    parameter int VB_ENTRIES  = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cpu_valid,
    input  logic                                      cpu_we,
    input  logic [ADDR_W-1:0]                         cpu_addr,
    input  logic [DATA_W-1:0]                         cpu_wdata,
    output logic [DATA_W-1:0]                         cpu_rdata,
    output logic                                      cpu_ready,
    output logic                                      mem_req,
    output logic                                      mem_we,
    output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]      mem_addr,
    output logic [DATA_W*LINE_WORDS-1:0]              mem_wdata,
    input  logic [DATA_W*LINE_WORDS-1:0]              mem_rdata,
    input  logic                                      mem_ack
);
    localparam int LINE_W = DATA_W * LINE_WORDS;
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int LINES  = CACHE_BYTES * 8 / LINE_W;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int SLOT_W = $clog2(VB_ENTRIES);

    // Word select from a line.
    function automatic logic [DATA_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                               input logic [OFF_W-1:0] o);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int k = 0; k < LINE_WORDS; k++)
            if (o == OFF_W'(k)) w = ln[k*DATA_W +: DATA_W];
        return w;
    endfunction

    // Replace one word of a line.
    function automatic logic [LINE_W-1:0] merge(input logic [LINE_W-1:0] ln,
                                                input logic [OFF_W-1:0] o,
                                                input logic [DATA_W-1:0] d);
        logic [LINE_W-1:0] r;
        r = ln;
        for (int k = 0; k < LINE_WORDS; k++)
            if (o == OFF_W'(k)) r[k*DATA_W +: DATA_W] = d;
        return r;
    endfunction

    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic [BLK_W-1:0] req_blk;
    assign req_off = cpu_addr[OFF_W-1:0];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_blk = cpu_addr[ADDR_W-1 -: BLK_W];

    ctl_state_e state_q, state_d;

    logic [TAG_W-1:0]  m_tag;
    logic [LINE_W-1:0] m_line;
    logic              m_valid, m_dirty, main_hit;
    logic              m_wr_en, m_wr_dirty;
    logic [LINE_W-1:0] m_wr_line;

    logic              vb_hit, vb_hit_dirty, vb_head_valid, vb_head_dirty;
    logic [SLOT_W-1:0] vb_hit_slot, vb_head_slot, vb_wr_slot;
    logic [LINE_W-1:0] vb_hit_line, vb_head_line;
    logic [BLK_W-1:0]  vb_head_blk;
    logic              vb_wr_en, vb_wr_valid, vb_wr_dirty, vb_adv;

    vc_main_array #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .rd_tag   (m_tag),
        .rd_line  (m_line),
        .rd_valid (m_valid),
        .rd_dirty (m_dirty),
        .wr_en    (m_wr_en),
        .wr_tag   (req_tag),
        .wr_line  (m_wr_line),
        .wr_dirty (m_wr_dirty)
    );

    vc_victim_buf #(.ENTRIES(VB_ENTRIES), .BLK_W(BLK_W), .LINE_W(LINE_W)) u_vb (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_blk   (req_blk),
        .hit        (vb_hit),
        .hit_slot   (vb_hit_slot),
        .hit_line   (vb_hit_line),
        .hit_dirty  (vb_hit_dirty),
        .head_slot  (vb_head_slot),
        .head_valid (vb_head_valid),
        .head_dirty (vb_head_dirty),
        .head_blk   (vb_head_blk),
        .head_line  (vb_head_line),
        .wr_en      (vb_wr_en),
        .wr_slot    (vb_wr_slot),
        .wr_valid   (vb_wr_valid),
        .wr_blk     ({m_tag, req_idx}),
        .wr_line    (m_line),
        .wr_dirty   (vb_wr_dirty),
        .advance    (vb_adv)
    );

    assign main_hit = m_valid && (m_tag == req_tag);

    // Controller: routes lines between the two stores and memory.
    always_comb begin
        state_d     = state_q;
        cpu_ready   = 1'b0;
        cpu_rdata   = pick(m_line, req_off);
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = req_blk;
        mem_wdata   = vb_head_line;
        m_wr_en     = 1'b0;
        m_wr_line   = m_line;
        m_wr_dirty  = 1'b0;
        vb_wr_en    = 1'b0;
        vb_wr_slot  = vb_head_slot;
        vb_wr_valid = m_valid;
        vb_wr_dirty = m_valid && m_dirty;
        vb_adv      = 1'b0;
        unique case (state_q)
            ST_IDLE: if (cpu_valid) begin
                if (main_hit) begin
                    cpu_ready  = 1'b1;
                    m_wr_en    = cpu_we;
                    m_wr_line  = merge(m_line, req_off, cpu_wdata);
                    m_wr_dirty = 1'b1;
                end else if (vb_hit) begin
                    state_d = ST_SWAP;
                end else if (m_valid && vb_head_valid && vb_head_dirty) begin
                    state_d = ST_WBACK;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_SWAP: begin
                cpu_ready  = 1'b1;
                cpu_rdata  = pick(vb_hit_line, req_off);
                m_wr_en    = 1'b1;
                m_wr_line  = cpu_we ? merge(vb_hit_line, req_off, cpu_wdata) : vb_hit_line;
                m_wr_dirty = vb_hit_dirty || cpu_we;
                vb_wr_en   = 1'b1;
                vb_wr_slot = vb_hit_slot;
                state_d    = ST_IDLE;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = vb_head_blk;
                mem_wdata = vb_head_line;
                if (mem_ack) state_d = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    cpu_ready  = 1'b1;
                    cpu_rdata  = pick(mem_rdata, req_off);
                    m_wr_en    = 1'b1;
                    m_wr_line  = cpu_we ? merge(mem_rdata, req_off, cpu_wdata) : mem_rdata;
                    m_wr_dirty = cpu_we;
                    vb_wr_en   = m_valid;
                    vb_adv     = m_valid;
                    state_d    = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Controller state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Memory request held steady until acknowledged.
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));
    // Victim hit never touches memory and lasts exactly one extra cycle.
    p_swap_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWAP) |-> !mem_req);
    p_swap_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWAP) |=> (state_q == ST_IDLE));
    // Only a live modified slot is ever written back.
    p_wb_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WBACK) |-> (vb_head_valid && vb_head_dirty));
    // The two stores never hold the same block.
    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_valid && main_hit) |-> !vb_hit);
    // No ready without a request.
    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> !cpu_ready);
endmodule

// File: tb/victim_dm_cache_tb.sv
module victim_dm_cache_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cpu_valid, cpu_we;
    logic [15:0]  cpu_addr;
    logic [31:0]  cpu_wdata, cpu_rdata;
    logic         cpu_ready;
    logic         mem_req, mem_we, mem_ack;
    logic [13:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata;

    int checks = 0, failures = 0;
    int rd_cnt = 0, wr_cnt = 0, rd_at_wr = 0;
    logic [13:0]  last_wr_addr;
    logic [127:0] last_wr_data;
    logic [127:0] store [int];
    bit done = 0;

    always #10 clk = ~clk;

    victim_dm_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [15:0] mk(input int tag, input int idx, input int off);
        return {6'(tag), 8'(idx), 2'(off)};
    endfunction

    function automatic logic [31:0] init_word(input logic [13:0] blk, input int off);
        return {2'b10, blk, 14'h0, 2'(off)};
    endfunction

    function automatic logic [127:0] init_line(input logic [13:0] blk);
        logic [127:0] l;
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = init_word(blk, k);
        return l;
    endfunction

    // Memory responder: acknowledges each request after three cycles.
    initial begin
        int cnt;
        cnt = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                cnt++;
                if (cnt == 3) begin
                    if (mem_we) begin
                        store[int'(mem_addr)] = mem_wdata;
                        wr_cnt++;
                        rd_at_wr = rd_cnt;
                        last_wr_addr = mem_addr;
                        last_wr_data = mem_wdata;
                    end else begin
                        mem_rdata = store.exists(int'(mem_addr)) ? store[int'(mem_addr)]
                                                                 : init_line(mem_addr);
                        rd_cnt++;
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 1;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1; cyc++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_valid = 1'b0; cpu_we = 1'b0;
    endtask

    logic [15:0] a0, b0;

    task automatic t_reset();
        check(cpu_ready == 1'b0, "R1 ready idle", 128'(cpu_ready), 0);
        check(mem_req == 1'b0, "R1 no mem req", 128'(mem_req), 0);
    endtask

    task automatic t_cold_and_hit();
        logic [31:0] d; int c, r0;
        access(0, a0, 0, d, c);
        check(d == init_word(a0[15:2], 1), "R1 cold read data", 128'(d), 128'(init_word(a0[15:2], 1)));
        check(rd_cnt == 1 && c > 2, "R1 cold miss fetch", 128'(rd_cnt), 1);
        r0 = rd_cnt;
        access(0, a0, 0, d, c);
        check(c == 1, "R2 hit latency", 128'(c), 1);
        check(rd_cnt == r0, "R2 hit no mem", 128'(rd_cnt), 128'(r0));
        access(1, a0, 32'h1111_1111, d, c);
        check(c == 1, "R2 write hit latency", 128'(c), 1);
        access(0, a0, 0, d, c);
        check(d == 32'h1111_1111, "R2 write hit data", 128'(d), 128'h1111_1111);
        access(0, mk(0, 3, 0), 0, d, c);
        check(d == init_word(a0[15:2], 0), "R2 other word intact", 128'(d), 128'(init_word(a0[15:2], 0)));
    endtask

    task automatic t_victim_swap();
        logic [31:0] d; int c, r0;
        access(0, b0, 0, d, c);
        check(d == init_word(b0[15:2], 0) && rd_cnt == 2, "R5 conflict fetch", 128'(d), 128'(init_word(b0[15:2], 0)));
        check(wr_cnt == 0, "R5 no write for empty slot", 128'(wr_cnt), 0);
        r0 = rd_cnt;
        access(0, a0, 0, d, c);
        check(c == 2, "R3 victim hit latency", 128'(c), 2);
        check(rd_cnt == r0 && wr_cnt == 0, "R3 victim hit no mem", 128'(rd_cnt), 128'(r0));
        check(d == 32'h1111_1111, "R7 dirty data via victim", 128'(d), 128'h1111_1111);
        access(0, b0, 0, d, c);
        check(c == 2 && d == init_word(b0[15:2], 0), "R4 swap back", 128'(c), 2);
        access(0, b0, 0, d, c);
        check(c == 1, "R4 swapped line now in main", 128'(c), 1);
    endtask

    task automatic t_fifo_writeback();
        logic [31:0] d; int c, r0;
        logic [127:0] exp;
        for (int t = 2; t <= 4; t++) begin
            access(0, mk(t, 3, 0), 0, d, c);
        end
        check(wr_cnt == 0, "R6 no write-back before wrap", 128'(wr_cnt), 0);
        r0 = rd_cnt;
        access(0, mk(5, 3, 2), 0, d, c);
        check(wr_cnt == 1, "R6 dirty head written back", 128'(wr_cnt), 1);
        check(last_wr_addr == a0[15:2], "R6 write-back address", 128'(last_wr_addr), 128'(a0[15:2]));
        exp = init_line(a0[15:2]);
        exp[32 +: 32] = 32'h1111_1111;
        check(last_wr_data == exp, "R7 write-back data", last_wr_data, exp);
        check(rd_at_wr == r0 && rd_cnt == r0 + 1, "R6 write before read", 128'(rd_at_wr), 128'(r0));
        access(0, a0, 0, d, c);
        check(d == 32'h1111_1111, "R6 evicted data recovered", 128'(d), 128'h1111_1111);
        check(wr_cnt == 1, "R6 clean slot dropped silently", 128'(wr_cnt), 1);
    endtask

    task automatic t_victim_write();
        logic [31:0] d; int c;
        access(1, mk(4, 3, 0), 32'h3333_3333, d, c);
        check(c == 2, "R4 write on victim hit latency", 128'(c), 2);
        access(0, mk(4, 3, 0), 0, d, c);
        check(c == 1 && d == 32'h3333_3333, "R4 merged victim write", 128'(d), 128'h3333_3333);
    endtask

    task automatic t_write_miss();
        logic [31:0] d; int c, w0;
        w0 = wr_cnt;
        access(1, mk(0, 9, 2), 32'h2222_2222, d, c);
        check(c > 2 && wr_cnt == w0, "R5 write miss allocates", 128'(c), 3);
        access(0, mk(0, 9, 2), 0, d, c);
        check(c == 1 && d == 32'h2222_2222, "R5 write miss merged", 128'(d), 128'h2222_2222);
        access(0, mk(0, 9, 0), 0, d, c);
        check(d == init_word(mk(0, 9, 0) >> 2, 0), "R5 fill keeps other words", 128'(d), 128'(init_word(mk(0, 9, 0) >> 2, 0)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        a0 = mk(0, 3, 1);
        b0 = mk(1, 3, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_cold_and_hit();
        t_victim_swap();
        t_fifo_writeback();
        t_victim_write();
        t_write_miss();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule